// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus master read and write an internal bank of byte-wide registers through a one-byte sub-address pointer. SCL and SDA are brought into the system clock domain through flop chains. Start and stop conditions are detected there, and a single state machine then walks through the address byte, the sub-address byte and the data bytes. Each of these bytes gets its own acknowledge phase. SDA is driven through an open-drain enable: a 1 on `sda_oe_o` pulls the line low.

A write transaction sends the device address with the direction bit at 0, then one sub-address byte, then any number of data bytes. The data bytes land in consecutive registers. A read needs two transactions. The first is a write that carries only the sub-address and ends with a stop. The second is a new start with the direction bit at 1, after which register bytes are shifted out until the master answers with a not-acknowledge. The pointer advances by one for every byte written or loaded for reading. It wraps from 0xFF to 0x00 and keeps its value while the bus is idle.

States: `ST_IDLE` (bus ignored until a start), `ST_DEVADDR` (receive the address byte), `ST_DEVACK` (acknowledge the address), `ST_SUBADDR` / `ST_SUBACK` (receive and acknowledge the sub-address), `ST_WDATA` / `ST_WACK` (receive and acknowledge a data byte), `ST_RDATA` (shift a register byte out) and `ST_RACK` (sample the master's acknowledge). The transitions are:
- From any state, a start goes to `ST_DEVADDR` and a stop goes to `ST_IDLE`.
- `ST_DEVADDR` goes to `ST_DEVACK` on an address match and to `ST_IDLE` otherwise.
- `ST_DEVACK` goes to `ST_SUBADDR` for a write and to `ST_RDATA` for a read.
- `ST_SUBADDR` goes to `ST_SUBACK`, and `ST_SUBACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WACK` alternate for as long as data bytes arrive.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` returns to `ST_RDATA` on an acknowledge and goes to `ST_IDLE` on a not-acknowledge.

Each of these transitions, apart from start and stop, takes place on a falling SCL edge once the byte or acknowledge bit in progress is complete.

Top module: `i2c_tgt`

## Requirements
- R1: A start (SDA falling while SCL is high) from any state begins a new address phase. A stop (SDA rising while SCL is high) returns the target to idle.
- R2: The 7-bit device address, sent MSB first after a start, is {1010, 0, strap_i, 0}, followed by the direction bit (0 = write, 1 = read). So strap_i=0 answers the bytes 0xA0/0xA1 and strap_i=1 answers 0xA4/0xA5. On a mismatch the target does not acknowledge, and it neither acknowledges nor writes anything until the next start.
- R3: The target acknowledges the matching address byte, the sub-address byte and every write data byte by holding SDA low during the ninth SCL clock.
- R4: In a write, the first byte after the address sets the pointer. Each later byte is written MSB first with a one-cycle `reg_we_o` pulse at `reg_addr_o` = pointer, and the pointer then advances by one.
- R5: The pointer wraps from 0xFF to 0x00 during both write and read bursts.
- R6: The pointer keeps its value across the stop that ends a sub-address-only write. The following read phase starts at that register.
- R7: In a read, register bytes are shifted out MSB first. A master acknowledge loads the next register and advances the pointer. A not-acknowledge releases SDA and returns the target to idle, leaving the pointer one past the last byte sent.
- R8: A start or stop in the middle of a data byte aborts it, and the partial byte is never written.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: While and after reset, `sda_oe_o` is 0, `reg_we_o` is 0 and the pointer (`reg_addr_o`) is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| strap_i | input | 1 | Selects device address bit 1 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr_o | output | 8 | Register bank address (the pointer) |
| reg_wdata_o | output | 8 | Register bank write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register bank read data at `reg_addr_o` |

## Verification
A scoreboard receives the expected register writes from the bit-banging master, and every write strobe must match the next entry. The stimulus patterns are chosen so that each one separates a different kind of fault:
- A multi-byte burst separates correct pointer stepping from a pointer that stays put.
- A burst that starts at 0xFE separates correct wrapping from overflow.
- Traffic sent to the other strap's address separates true address matching from an address that is not decoded, since the target must stay silent and write nothing.
- A sub-address-only write, a stop, and then reads ended by a not-acknowledge show whether the pointer survives the stop and whether it advances only on loaded bytes.
- Data bytes cut off by a stop and by a repeated start show whether partial bytes are discarded, because any spurious write reaches the scoreboard as an unexpected item.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_SUBADDR,
        ST_SUBACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Brings SCL/SDA into the clock domain and derives edge and bus-condition pulses.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s    = scl_p[STAGES-1];
    assign sda_s    = sda_p[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_shreg.sv
// Shared byte shifter: receives on SCL rise, transmits on SCL fall, counts bits.
module i2c_tgt_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         rx_bit,
    input  logic         sda,
    input  logic         tx_tick,
    input  logic         tx_shift,
    output logic [W-1:0] data,
    output logic         full
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            data <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt  <= '0;
            data <= ld_val;
        end else begin
            if (rx_bit) begin
                data <= {data[W-2:0], sda};
                cnt  <= cnt + 1'b1;
            end else if (tx_tick) begin
                cnt <= cnt + 1'b1;
            end
            if (tx_shift) begin
                data <= {data[W-2:0], 1'b0};
            end
        end
    end

    assign full = (cnt == CNT_FULL);
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_HI      = 4'b1010,
    parameter logic [2:0] DEV_LO      = 3'b000,
    parameter int         STRAP_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    localparam logic [6:0] DEV_BASE = {DEV_HI, DEV_LO};

    tgt_state_e        state, nxt;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic [BYTE_W-1:0] sh_data;
    logic              sh_full, sh_clr, sh_load, rx_bit, tx_tick, tx_shift;
    logic              rx_state, bus_evt, dev_match, rw_q, ack_q;
    logic [6:0]        dev_id;
    logic [BYTE_W-1:0] ptr_q;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    i2c_tgt_shreg #(.W(BYTE_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load), .ld_val(reg_rdata_i),
        .rx_bit(rx_bit), .sda(sda_s), .tx_tick(tx_tick), .tx_shift(tx_shift),
        .data(sh_data), .full(sh_full)
    );

    always_comb begin
        dev_id            = DEV_BASE;
        dev_id[STRAP_BIT] = strap_i;
    end

    assign dev_match = (sh_data[BYTE_W-1:1] == dev_id);
    assign bus_evt   = start_c | stop_c;
    assign rx_state  = (state == ST_DEVADDR) || (state == ST_SUBADDR) || (state == ST_WDATA);
    assign rx_bit    = scl_rise & rx_state;
    assign tx_tick   = scl_rise & (state == ST_RDATA);
    assign tx_shift  = scl_fall & (state == ST_RDATA) & ~sh_full;
    assign sh_clr    = bus_evt | (scl_fall & (((state == ST_DEVACK) & ~rw_q) |
                                              (state == ST_SUBACK) | (state == ST_WACK)));
    assign sh_load   = ~bus_evt & scl_fall & (((state == ST_DEVACK) & rw_q) |
                                              ((state == ST_RACK) & ack_q));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start_c) begin
            nxt = ST_DEVADDR;
        end else if (stop_c) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_DEVADDR: if (scl_fall && sh_full) nxt = dev_match ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_SUBADDR;
                ST_SUBADDR: if (scl_fall && sh_full) nxt = ST_SUBACK;
                ST_SUBACK:  if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:   if (scl_fall && sh_full) nxt = ST_WACK;
                ST_WACK:    if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:   if (scl_fall && sh_full) nxt = ST_RACK;
                ST_RACK:    if (scl_fall) nxt = ack_q ? ST_RDATA : ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o    <= 1'b0;
            reg_we_o    <= 1'b0;
            reg_wdata_o <= '0;
            ptr_q       <= '0;
            rw_q        <= 1'b0;
            ack_q       <= 1'b0;
        end else begin
            reg_we_o <= 1'b0;
            if (reg_we_o || sh_load) ptr_q <= ptr_q + 1'b1;
            if (bus_evt) begin
                sda_oe_o <= 1'b0;
            end else begin
                if (scl_rise && state == ST_RACK) ack_q <= ~sda_s;
                if (scl_fall) begin
                    unique case (state)
                        ST_IDLE: sda_oe_o <= 1'b0;
                        ST_DEVADDR: if (sh_full) begin
                            sda_oe_o <= dev_match;
                            rw_q     <= sh_data[0];
                        end
                        ST_DEVACK: sda_oe_o <= rw_q & ~reg_rdata_i[BYTE_W-1];
                        ST_SUBADDR: if (sh_full) begin
                            sda_oe_o <= 1'b1;
                            ptr_q    <= sh_data;
                        end
                        ST_SUBACK: sda_oe_o <= 1'b0;
                        ST_WDATA: if (sh_full) begin
                            sda_oe_o    <= 1'b1;
                            reg_we_o    <= 1'b1;
                            reg_wdata_o <= sh_data;
                        end
                        ST_WACK:  sda_oe_o <= 1'b0;
                        ST_RDATA: sda_oe_o <= sh_full ? 1'b0 : ~sh_data[BYTE_W-2];
                        ST_RACK:  sda_oe_o <= ack_q & ~reg_rdata_i[BYTE_W-1];
                        default:  sda_oe_o <= 1'b0;
                    endcase
                end
            end
        end
    end

    assign reg_addr_o = ptr_q;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_c,
    input logic              stop_c,
    input tgt_state_e        state,
    input logic              sda_oe_o,
    input logic              reg_we_o,
    input logic [BYTE_W-1:0] reg_addr_o
);
    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> state == ST_DEVADDR);

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_c && !start_c) |=> state == ST_IDLE);

    // R5 is covered as well: the step is modulo 256
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> reg_addr_o == $past(reg_addr_o) + 8'd1);

    assert_we_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> state == ST_WACK);

    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe_o);

    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c), .stop_c(stop_c),
    .state(state), .sda_oe_o(sda_oe_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_tgt_tb.sv
`timescale 1ns/1ps
module i2c_tgt_tb;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       strap = 1'b0;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire        sda_bus = ~(m_sda_low | sda_oe);

    logic [7:0]  bank  [256];
    logic [7:0]  model [256];
    logic [15:0] wq [$];
    logic [7:0]  wbuf [8];
    int n_chk = 0, n_err = 0, oe_viol = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    i2c_tgt u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
        .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[i]  = 8'(i) ^ 8'h5A;
            model[i] = 8'(i) ^ 8'h5A;
        end
    end

    // Register bank and write scoreboard monitor (R4)
    always @(posedge clk) begin
        if (rst_n && reg_we) begin
            bank[reg_addr] <= reg_wdata;
            if (wq.size() == 0) chk(1'b0, "R4/R8 unexpected write", {reg_addr, reg_wdata}, 16'h0);
            else begin
                logic [15:0] e;
                e = wq.pop_front();
                chk({reg_addr, reg_wdata} == e, "R4 write", {reg_addr, reg_wdata}, e);
            end
        end
    end

    // R9 monitor: enable may only move while SCL is low
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && m_scl) oe_viol++;
        prev_oe <= sda_oe;
    end

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; half();
        m_scl = 1'b1;     half();
        m_sda_low = 1'b1; half();
        m_scl = 1'b0;     half();
    endtask

    task automatic bus_stop();
        repeat (2) @(negedge clk);
        m_sda_low = 1'b1; half();
        m_scl = 1'b1;     half();
        m_sda_low = 1'b0; half();
    endtask

    task automatic clock_bit(input bit b, output bit r);
        repeat (2) @(negedge clk);
        m_sda_low = ~b; half();
        m_scl = 1'b1;   half();
        r = sda_bus;
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] b);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            b[i] = r;
        end
        clock_bit(~m_ack, r);
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] sub, input int n, input bit match);
        bit ack;
        logic [7:0] a;
        bus_start();
        send_byte(dev, ack);
        chk(ack == match, "R2 address ack", 16'(ack), 16'(match));
        send_byte(sub, ack);
        chk(ack == match, match ? "R3 sub-address ack" : "R2 ignored sub", 16'(ack), 16'(match));
        for (int i = 0; i < n; i++) begin
            a = sub + 8'(i);
            if (match) begin
                wq.push_back({a, wbuf[i]});
                model[a] = wbuf[i];
            end
            send_byte(wbuf[i], ack);
            chk(ack == match, match ? "R3 data ack" : "R2 ignored data", 16'(ack), 16'(match));
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] dev, input logic [7:0] sp, input int n, input string req);
        bit ack;
        logic [7:0] b, a;
        bus_start();
        send_byte(dev, ack);
        chk(ack, "R2 read address ack", 16'(ack), 16'h1);
        for (int i = 0; i < n; i++) begin
            a = sp + 8'(i);
            recv_byte(i != n - 1, b);
            chk(b == model[a], req, 16'(b), 16'(model[a]));
        end
        bus_stop();
    endtask

    initial begin : main
        bit ack, r;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 oe in reset", 16'(sda_oe), 16'h0);
        chk(reg_we == 1'b0, "R10 we in reset", 16'(reg_we), 16'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(reg_addr == 8'h00, "R10 pointer after reset", 16'(reg_addr), 16'h0);

        // R3/R4: burst write at strap 0
        wbuf[0] = 8'h11; wbuf[1] = 8'hC3; wbuf[2] = 8'h7E;
        do_write(8'hA0, 8'h10, 3, 1'b1);

        // R2: other strap address is ignored
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
        do_write(8'hA4, 8'h20, 2, 1'b0);

        // R2/R5: strap 1, burst wraps past 0xFF
        strap = 1'b1;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC4;
        do_write(8'hA4, 8'hFE, 3, 1'b1);
        chk(reg_addr == 8'h01, "R5 pointer wrapped", 16'(reg_addr), 16'h01);

        // R6/R7: set pointer, stop, then read three bytes
        do_write(8'hA4, 8'h10, 0, 1'b1);
        chk(reg_addr == 8'h10, "R6 pointer held over stop", 16'(reg_addr), 16'h10);
        do_read(8'hA5, 8'h10, 3, "R7 read burst");
        repeat (4) @(negedge clk);
        chk(reg_addr == 8'h13, "R7 pointer after NACK", 16'(reg_addr), 16'h13);
        chk(sda_oe == 1'b0, "R7 SDA released", 16'(sda_oe), 16'h0);

        // R5/R7: read wrap
        do_write(8'hA4, 8'hFF, 0, 1'b1);
        do_read(8'hA5, 8'hFF, 2, "R5 read wrap");

        // R8: partial byte then stop
        bus_start();
        send_byte(8'hA4, ack);
        send_byte(8'h40, ack);
        wq.push_back({8'h40, 8'h55}); model[8'h40] = 8'h55;
        send_byte(8'h55, ack);
        chk(ack, "R3 data ack before abort", 16'(ack), 16'h1);
        for (int i = 0; i < 4; i++) clock_bit(i[0], r);
        bus_stop();

        // R8: partial byte then repeated start
        bus_start();
        send_byte(8'hA4, ack);
        send_byte(8'h41, ack);
        for (int i = 0; i < 5; i++) clock_bit(1'b0, r);
        bus_start();
        send_byte(8'hA4, ack);
        chk(ack, "R1 repeated start address", 16'(ack), 16'h1);
        send_byte(8'h60, ack);
        wq.push_back({8'h60, 8'h77}); model[8'h60] = 8'h77;
        send_byte(8'h77, ack);
        bus_stop();

        do_write(8'hA4, 8'h40, 0, 1'b1);
        do_read(8'hA5, 8'h40, 2, "R8 aborted bytes unwritten");

        repeat (20) @(negedge clk);
        chk(wq.size() == 0, "R4 all writes seen", 16'(wq.size()), 16'h0);
        chk(oe_viol == 0, "R9 oe moves only with SCL low", 16'(oe_viol), 16'h0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule